// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory

This block models a byte-wide programmable read-only memory for use inside a larger chip. One enable selects the device. A second enable turns its data outputs on. An active-low program strobe, qualified by a single "programming supply present" bit, writes data into the array. Several such memories can sit on one shared data bus. A device drives the bus only while it is selected and its outputs are enabled. At all other times it floats the bus, shown here by an output-enable bit.

A fresh array holds all ones. A program pulse can only clear bits, so a cell becomes the AND of its old value and the byte on the data inputs. The strobe is sampled in the clock domain. One write happens on each high-to-low transition of the strobe while the device is in program mode. Addresses may be programmed in any order. The erasable variant has a synchronous erase-all input that restores every cell to ones. The one-time variant ignores that input.

The address width is a parameter. The default of 10 bits gives 1K x 8, and 14 bits gives 16K x 8.

Top module: `otp_byte_mem`

## Requirements
- R1: With ce_n=0 and oe_n=0, dq_oe is 1 and dq_o shows the byte stored at addr, combinationally, including during a verify read with vpp_on=1.
- R2: With ce_n=1 (deselect), dq_oe is 0 whatever oe_n is, and no strobe edge changes any cell.
- R3: After reset every cell reads 8'hFF.
- R4: The stored byte becomes old & dq_i at a rising clock edge if all of the following hold at that edge: pgm_n is sampled 0, pgm_n was 1 at the previous edge, ce_n=0, oe_n=1 and vpp_on=1. The new value is readable after that edge.
- R5: Programming never turns a 0 bit back into 1. Writing 8'hFF leaves the cell unchanged.
- R6: Programming is inhibited when vpp_on=0, when oe_n=0, or when pgm_n is held either high or low. Holding pgm_n low for several cycles gives exactly one write.
- R7: In program mode (ce_n=0, oe_n=1), dq_oe is 0, so the bus acts as an input.
- R8: Locations are programmed independently and in any order. A write touches only the addressed cell.
- R9: With ERASABLE=1, erase_all=1 at a clock edge sets every cell to 8'hFF. It takes priority over a program pulse at the same edge.
- R10: With ERASABLE=0, erase_all has no effect on any cell.
- R11: Whenever dq_oe is 0, dq_o is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_on | input | 1 | Programming supply present |
| erase_all | input | 1 | Synchronous erase of the whole array |
| addr | input | ADDR_W | Byte address |
| dq_i | input | DATA_W | Data to program |
| dq_o | output | DATA_W | Data driven onto the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The bench builds two instances with ADDR_W=5, so the whole 32-word array can be swept after reset and after an erase. One instance has ERASABLE=1 and the other ERASABLE=0. Both receive the same stimulus, so one erase pulse shows the restore on the first instance and the ignore on the second (R9 and R10). The small depth also lets writes at scattered addresses be checked against their neighbours.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [1:0] {
    OP_DESELECT = 2'd0,
    OP_STANDBY  = 2'd1,
    OP_READ     = 2'd2,
    OP_PROGRAM  = 2'd3
  } op_mode_e;
endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
  import otp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ce_n,
  input  logic     oe_n,
  input  logic     vpp_on,
  output op_mode_e mode,
  output logic     out_en,
  output logic     prog_ok
);
  always_comb begin
    if (ce_n)          mode = OP_DESELECT;
    else if (!oe_n)    mode = OP_READ;
    else if (vpp_on)   mode = OP_PROGRAM;
    else               mode = OP_STANDBY;
  end

  assign out_en  = (mode == OP_READ);
  assign prog_ok = (mode == OP_PROGRAM);

  AST_BUS_DIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_en, prog_ok})); // R7
endmodule

// File: rtl/otp_strobe_edge.sv
module otp_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pgm_n,
  input  logic arm,
  output logic wr_pulse
);
  logic pgm_q;
  logic pgm_d;

  always_comb pgm_d = pgm_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pgm_q <= 1'b1;
    else        pgm_q <= pgm_d;
  end

  assign wr_pulse = arm & pgm_q & ~pgm_n;

  AST_ONE_WRITE_PER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse); // R6
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 8,
  parameter bit ERASABLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              erase_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];
  logic              erase_en;

  generate
    if (ERASABLE) begin : g_erase
      assign erase_en = erase_req;
      AST_ERASE_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |=> (cells[rd_addr] == {DATA_W{1'b1}})); // R9
    end else begin : g_no_erase
      assign erase_en = erase_req & 1'b0;
    end
  endgenerate

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic              hit;
    logic              upd;
    logic [DATA_W-1:0] word_d;
    logic [DATA_W-1:0] word_q;

    always_comb begin
      hit    = wr_en && (wr_addr == ADDR_W'(w));
      upd    = erase_en || hit;
      word_d = word_q;
      if (erase_en)  word_d = {DATA_W{1'b1}};
      else if (hit)  word_d = word_q & wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= {DATA_W{1'b1}};
      else if (upd) word_q <= word_d;
    end

    assign cells[w] = word_q;
  end

  assign rd_data = cells[rd_addr];

  AST_PROG_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !erase_en) |=>
      (cells[$past(wr_addr)] == ($past(cells[wr_addr]) & $past(wr_data)))); // R4
  AST_NO_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !erase_en) |=>
      ((cells[$past(wr_addr)] & ~$past(cells[wr_addr])) == '0)); // R5
endmodule

// File: rtl/otp_byte_mem.sv
module otp_byte_mem #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 8,
  parameter bit ERASABLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_on,
  input  logic              erase_all,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe
);
  import otp_pkg::*;

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  op_mode_e          mode;
  logic              out_en;
  logic              prog_ok;
  logic              wr_pulse;
  logic [DATA_W-1:0] rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  otp_mode_dec u_dec (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .vpp_on  (vpp_on),
    .mode    (mode),
    .out_en  (out_en),
    .prog_ok (prog_ok)
  );

  otp_strobe_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pgm_n    (pgm_n),
    .arm      (prog_ok),
    .wr_pulse (wr_pulse)
  );

  otp_cell_array #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .ERASABLE (ERASABLE)
  ) u_array (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (wr_pulse),
    .wr_addr   (addr),
    .wr_data   (dq_i),
    .erase_req (erase_all),
    .rd_addr   (addr),
    .rd_data   (rd_data)
  );

  assign dq_oe = out_en;
  assign dq_o  = out_en ? rd_data : '0;

  AST_DESELECT_FLOATS: assert property (@(posedge clk) disable iff (!rst_int_n)
    ce_n |-> !dq_oe); // R2
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_int_n)
    !dq_oe |-> (dq_o == '0)); // R11
  AST_NO_WRITE_DESELECT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ce_n || oe_n == 1'b0 || !vpp_on) |-> !wr_pulse); // R6
endmodule

// File: tb/otp_byte_mem_bench.sv
module otp_byte_mem_bench;
  localparam int CLK_P  = 10;
  localparam int AW     = 5;
  localparam int DEPTH  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n, ce_n, oe_n, pgm_n, vpp_on, erase_all;
  logic [AW-1:0] addr;
  logic [7:0]    dq_i;
  logic [7:0]    dq_o_e, dq_o_p;
  logic          dq_oe_e, dq_oe_p;

  int checks = 0;
  int errors = 0;
  int mem_e [DEPTH];
  int mem_p [DEPTH];
  bit pgm_prev = 1'b1;

  always #(CLK_P/2) clk = ~clk;

  otp_byte_mem #(.ADDR_W(AW), .DATA_W(8), .ERASABLE(1'b1)) u_otp_byte_mem (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_on(vpp_on), .erase_all(erase_all), .addr(addr), .dq_i(dq_i),
    .dq_o(dq_o_e), .dq_oe(dq_oe_e));

  otp_byte_mem #(.ADDR_W(AW), .DATA_W(8), .ERASABLE(1'b0)) u_otp_byte_mem_otp (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_on(vpp_on), .erase_all(erase_all), .addr(addr), .dq_i(dq_i),
    .dq_o(dq_o_p), .dq_oe(dq_oe_p));

  task automatic check(input string tag, input string who, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, who, got, exp);
    end
  endtask

  task automatic cyc(input bit c, input bit o, input bit p, input bit v, input bit er,
                     input int a, input int d, input string tag);
    int exp_oe;
    @(negedge clk);
    ce_n = c; oe_n = o; pgm_n = p; vpp_on = v; erase_all = er;
    addr = AW'(a); dq_i = 8'(d);
    #(CLK_P/4);
    exp_oe = (!c && !o) ? 1 : 0;
    check(tag, "erasable", {23'd0, dq_oe_e, dq_o_e}, (exp_oe << 8) | (exp_oe ? mem_e[a] : 0));
    check(tag, "otp",      {23'd0, dq_oe_p, dq_o_p}, (exp_oe << 8) | (exp_oe ? mem_p[a] : 0));
    @(posedge clk);
    if (!c && o && v && pgm_prev && !p) begin
      if (!er) mem_e[a] = mem_e[a] & d;
      mem_p[a] = mem_p[a] & d;
    end
    if (er) for (int i = 0; i < DEPTH; i++) mem_e[i] = 8'hFF;
    pgm_prev = p;
  endtask

  task automatic prog(input int a, input int d, input string tag);
    cyc(0, 1, 1, 1, 0, a, d, "R7");
    cyc(0, 1, 0, 1, 0, a, d, tag);
    cyc(0, 1, 1, 1, 0, a, d, "R7");
  endtask

  task automatic rd(input int a, input string tag);
    cyc(0, 0, 1, 0, 0, a, 0, tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mem_e[i] = 8'hFF; mem_p[i] = 8'hFF; end
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; pgm_n = 1'b1; vpp_on = 1'b0;
    erase_all = 1'b0; addr = '0; dq_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    for (int a = 0; a < DEPTH; a++) rd(a, "R3");
    cyc(1, 0, 1, 0, 0, 4, 0, "R2");
    cyc(1, 1, 1, 0, 0, 4, 0, "R11");
    cyc(0, 1, 1, 0, 0, 4, 0, "R11");

    // R4 single write, R6 strobe held low gives one write only
    cyc(0, 1, 1, 1, 0, 3, 8'hA5, "R7");
    cyc(0, 1, 0, 1, 0, 3, 8'hA5, "R4");
    cyc(0, 1, 0, 1, 0, 3, 8'h0F, "R6");
    cyc(0, 1, 1, 1, 0, 3, 8'h0F, "R6");
    cyc(0, 0, 1, 1, 0, 3, 0, "R1");
    rd(3, "R4");

    // R5 bits never come back
    prog(3, 8'hFF, "R5");
    rd(3, "R5");
    prog(3, 8'hF0, "R5");
    rd(3, "R5");

    // R8 arbitrary order
    prog(20, 8'h3C, "R8");
    prog(1, 8'h81, "R8");
    prog(31, 8'h00, "R8");
    for (int a = 0; a < DEPTH; a++) rd(a, "R8");

    // R6 inhibits: no supply, outputs on, deselect
    cyc(0, 1, 1, 0, 0, 7, 8'h00, "R6");
    cyc(0, 1, 0, 0, 0, 7, 8'h00, "R6");
    cyc(0, 0, 1, 1, 0, 8, 8'h00, "R6");
    cyc(0, 0, 0, 1, 0, 8, 8'h00, "R6");
    cyc(1, 1, 1, 1, 0, 9, 8'h00, "R2");
    cyc(1, 1, 0, 1, 0, 9, 8'h00, "R2");
    cyc(1, 1, 1, 1, 0, 9, 8'h00, "R2");
    rd(7, "R6"); rd(8, "R6"); rd(9, "R2");

    // R9 erase wins over a simultaneous pulse, R10 one-time variant keeps data
    cyc(0, 1, 1, 1, 0, 5, 8'h11, "R7");
    cyc(0, 1, 0, 1, 1, 5, 8'h11, "R9");
    cyc(0, 1, 1, 1, 0, 5, 8'h11, "R10");
    for (int a = 0; a < DEPTH; a++) rd(a, "R9");
    rd(3, "R10"); rd(5, "R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule